// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a 512-byte serial memory that sits on a two-wire (I2C) bus as a slave. It samples the clock and data lines with a fast system clock and finds START and STOP conditions. It decodes the control byte against two chip-select strap inputs and returns acknowledges by pulling the data line low through an open-drain output enable. It keeps a 9-bit address pointer, serves current-address, random and sequential reads from an external memory read port, and hands every accepted write byte, with its address, to a separate page-buffer block. A STOP that closes a write with data is flagged so the page buffer can start its programming cycle.

The self-timed programming sequencer and the analog input filters live elsewhere. The sequencer reports a running cycle on `prog_busy`. While that input is high the engine acknowledges nothing, so a master can poll with control bytes until the cycle ends. The memory read port is combinational: `mem_rdata` must reflect `mem_raddr` within one system clock.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and neither `wr_valid` nor `wr_commit` pulses until a bus transaction produces one.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START in any state, including part-way through a byte, restarts control-byte reception. A STOP returns to idle and releases SDA.
- R3: A control byte matches when its top four bits are 1010 and its next two bits equal `chip_sel[1]` and `chip_sel[0]`. Bit 1 is the block-select bit and bit 0 is the direction (1 = read). On a match the engine holds `sda_oe` high for the whole SCL high phase of the 9th clock.
- R4: A control byte that does not match gets no acknowledge. All later bytes are ignored, with SDA never driven, until the next START.
- R5: While `prog_busy` is high, no byte gets an acknowledge, including a matching control byte, and no write byte is delivered.
- R6: An accepted control byte loads pointer bit 8 from its block-select bit. On a write, the following byte is acknowledged and loads pointer bits 7..0.
- R7: Every further byte of a write is acknowledged and presented as a one-cycle `wr_valid` pulse with `wr_data` and `wr_addr` equal to the pointer. The pointer then increments.
- R8: A STOP that ends a write in which at least one data byte was accepted gives a single-cycle `wr_commit`. A write that ends before any data byte gives none.
- R9: In read mode the engine shifts out the byte at the pointer MSB first, increments the pointer, and sends the next byte only after a master acknowledge. After a not-acknowledge it leaves SDA released.
- R10: A pointer increment wraps from offset 0xFF back to 0x00 of the same 256-byte block. Bit 8 never changes on an increment.
- R11: A read control byte that is not preceded by a word address reads from the current pointer (block-select bit as bit 8, low bits as left by the last access).
- R12: `sda_oe` changes only in the cycle after a detected SCL falling edge or after a START or STOP, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| chip_sel | input | 2 | Strap levels compared with control-byte bits 3 and 2 |
| prog_busy | input | 1 | High while a programming cycle runs |
| mem_raddr | output | 9 | Memory read address (the address pointer) |
| mem_rdata | input | 8 | Memory read data for `mem_raddr` |
| wr_valid | output | 1 | One-cycle pulse: a write byte was accepted |
| wr_addr | output | 9 | Address of the accepted write byte |
| wr_data | output | 8 | Accepted write byte |
| wr_commit | output | 1 | One-cycle pulse on a STOP that closes a write with data |

## Verification
The bench goes after pointer wrap in both blocks, on reads and on writes. An increment that carries into bit 8 would return data from the wrong block, or deliver a write at 0x000 instead of 0x100. Mismatched device code, mismatched chip select and a raised busy line are each sent with the master releasing SDA during the ack clock and during following bytes. An engine that acknowledged wrongly or kept listening would show a low pull where none is allowed. A START dropped into the middle of a control byte, followed by a current-address read, catches an engine that keeps the stale bit count or forgets the pointer between transactions. A write aborted by busy before any data byte would expose a commit raised without data.

// File: rtl/twi_mem_pkg.sv
// Package: shared types and constants of the two-wire memory slave.
// Assumes: one device code for the whole family of parts.
package twi_mem_pkg;

    // Transaction phase of the slave engine
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a START
        ST_CTRL,    // receiving the control byte
        ST_WADDR,   // receiving the word address
        ST_WDATA,   // receiving write data
        ST_RDATA,   // transmitting read data
        ST_SKIP     // not addressed; wait for START or STOP
    } twi_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/twi_bus_sampler.sv
// Module: twi_bus_sampler
// Synchronises SCL and SDA into the system clock domain and flags SCL
// edges and START/STOP conditions on the synchronised levels.
// Assumes: the system clock runs several times faster than SCL, and both
// lines idle high (the reset value of the synchronisers).
module twi_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_now, scl_prev, sda_now, sda_prev;

    // Shift both lines through the synchroniser plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_in};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_in};
        end
    end

    assign scl_now  = scl_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_now  = sda_pipe[SYNC_STAGES-1];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    // Decode edges and bus conditions from the current and previous samples
    always_comb begin
        sda_lvl   = sda_now;
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_evt = scl_now & scl_prev & sda_prev & ~sda_now;
        stop_evt  = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/twi_addr_ptr.sv
// Module: twi_addr_ptr
// Address pointer split into a block part (upper bits) and an offset part
// (lower BLK_W bits). Increments touch only the offset and wrap inside the
// block.
// Assumes: at most one of the load/increment strobes is high per cycle.
module twi_addr_ptr #(
    parameter int ADDR_W = 9,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic [ADDR_W-BLK_W-1:0] hi_val,
    input  logic              load_lo,
    input  logic [BLK_W-1:0]  lo_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - BLK_W;

    logic [HI_W-1:0]  ptr_hi;
    logic [BLK_W-1:0] ptr_lo;

    // Block part changes only on an explicit load
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_hi <= '0;
        else if (load_hi) ptr_hi <= hi_val;
    end

    // Offset part loads from the word address or counts modulo the block size
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_lo <= '0;
        else if (load_lo) ptr_lo <= lo_val;
        else if (inc)     ptr_lo <= ptr_lo + 1'b1;
    end

    assign ptr = {ptr_hi, ptr_lo};

endmodule

// File: rtl/twi_slave_ctl.sv
// Module: twi_slave_ctl
// Byte-level protocol engine: counts bits, decodes the control byte,
// decides acknowledges, drives read data and emits write bytes.
// Assumes: events come from twi_bus_sampler; rd_data is valid for the
// current pointer; SDA drive changes only on a detected SCL fall.
module twi_slave_ctl
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [1:0]        chip_sel,
    input  logic              prog_busy,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [7:0]        rd_data,
    output logic              ld_hi,
    output logic [ADDR_W-BLK_W-1:0] hi_val,
    output logic              ld_lo,
    output logic [BLK_W-1:0]  lo_val,
    output logic              ptr_inc,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int HI_W = ADDR_W - BLK_W;
    localparam logic [3:0] ACK_BIT = 4'd8;
    localparam logic [3:0] ACK_END = 4'd9;

    twi_state_t  state;
    logic [3:0]  bit_cnt;
    logic [7:0]  rx_sr;
    logic [7:0]  tx_sr;
    logic        rd_go;
    logic        got_data;
    logic        byte_done, ack_end, code_ok;
    logic        data_take, rd_load;

    // Decode byte boundaries, address match and pointer strobes
    always_comb begin
        byte_done = scl_fall && (bit_cnt == ACK_BIT);
        ack_end   = scl_fall && (bit_cnt == ACK_END);
        code_ok   = (rx_sr[7:4] == DEV_CODE) && (rx_sr[3:2] == chip_sel);
        ld_hi     = (state == ST_CTRL) && byte_done && code_ok && !prog_busy;
        hi_val    = {HI_W{rx_sr[1]}};
        ld_lo     = (state == ST_WADDR) && byte_done && !prog_busy;
        lo_val    = rx_sr[BLK_W-1:0];
        data_take = (state == ST_WDATA) && byte_done && !prog_busy;
        rd_load   = (state == ST_RDATA) && ack_end && rd_go;
        ptr_inc   = data_take || rd_load;
    end

    // Main sequencer: bit counting, acknowledge, read shifting, write output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rd_go     <= 1'b0;
            got_data  <= 1'b0;
            sda_oe    <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            if (start_evt) begin
                state    <= ST_CTRL;
                bit_cnt  <= '0;
                sda_oe   <= 1'b0;
                rd_go    <= 1'b0;
                got_data <= 1'b0;
            end else if (stop_evt) begin
                wr_commit <= (state == ST_WDATA) && got_data;
                state    <= ST_IDLE;
                bit_cnt  <= '0;
                sda_oe   <= 1'b0;
                rd_go    <= 1'b0;
                got_data <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < ACK_BIT) begin
                        rx_sr   <= {rx_sr[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (bit_cnt == ACK_BIT) begin
                        bit_cnt <= ACK_END;
                        if (state == ST_RDATA) rd_go <= !sda_lvl;
                    end
                end
                if (byte_done) begin
                    unique case (state)
                        ST_CTRL: begin
                            if (code_ok && !prog_busy) begin
                                sda_oe <= 1'b1;
                                rd_go  <= rx_sr[0];
                                state  <= rx_sr[0] ? ST_RDATA : ST_WADDR;
                            end else begin
                                state  <= ST_SKIP;
                            end
                        end
                        ST_WADDR: begin
                            if (!prog_busy) begin
                                sda_oe <= 1'b1;
                                state  <= ST_WDATA;
                            end else begin
                                state  <= ST_SKIP;
                            end
                        end
                        ST_WDATA: begin
                            if (!prog_busy) begin
                                sda_oe   <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= rx_sr;
                                got_data <= 1'b1;
                            end else begin
                                state    <= ST_SKIP;
                            end
                        end
                        ST_RDATA: sda_oe <= 1'b0;
                        default:  sda_oe <= 1'b0;
                    endcase
                end else if (ack_end) begin
                    bit_cnt <= '0;
                    sda_oe  <= 1'b0;
                    if (state == ST_RDATA) begin
                        if (rd_go) begin
                            tx_sr  <= rd_data;
                            sda_oe <= !rd_data[7];
                        end else begin
                            state  <= ST_SKIP;
                        end
                    end
                end else if (scl_fall && (state == ST_RDATA) &&
                             (bit_cnt != 4'd0) && (bit_cnt < ACK_BIT)) begin
                    tx_sr  <= {tx_sr[6:0], 1'b0};
                    sda_oe <= !tx_sr[6];
                end
            end
        end
    end

endmodule

// File: rtl/twi_mem_slave.sv
// Module: twi_mem_slave (top)
// Two-wire bus slave for a block-organised serial memory: bus sampling,
// protocol engine and address pointer.
// Assumes: mem_rdata follows mem_raddr combinationally; the programming
// sequencer raises prog_busy for the whole of a programming cycle.
module twi_mem_slave #(
    parameter int ADDR_W      = 9,
    parameter int BLK_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [1:0]        chip_sel,
    input  logic              prog_busy,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int HI_W = ADDR_W - BLK_W;

    logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic ld_hi, ld_lo, ptr_inc;
    logic [HI_W-1:0]  hi_val;
    logic [BLK_W-1:0] lo_val;
    logic [ADDR_W-1:0] ptr;

    twi_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    twi_slave_ctl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .chip_sel  (chip_sel),
        .prog_busy (prog_busy),
        .ptr       (ptr),
        .rd_data   (mem_rdata),
        .ld_hi     (ld_hi),
        .hi_val    (hi_val),
        .ld_lo     (ld_lo),
        .lo_val    (lo_val),
        .ptr_inc   (ptr_inc),
        .sda_oe    (sda_oe),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit)
    );

    twi_addr_ptr #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (ld_hi),
        .hi_val  (hi_val),
        .load_lo (ld_lo),
        .lo_val  (lo_val),
        .inc     (ptr_inc),
        .ptr     (ptr)
    );

    assign mem_raddr = ptr;

endmodule

// File: rtl/twi_mem_slave_chk.sv
// Module: twi_mem_slave_chk
// Protocol properties of twi_mem_slave, attached by bind.
// Assumes: the sampler events are observed through the top's internal nets.
module twi_mem_slave_chk #(
    parameter int ADDR_W = 9,
    parameter int BLK_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_fall,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic              prog_busy,
    input logic              wr_valid,
    input logic              wr_commit,
    input logic [ADDR_W-1:0] mem_raddr
);
    // R12: the drive moves only after an SCL fall or a bus condition
    a_r12_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_evt || stop_evt));

    // R2: a STOP leaves the data line released
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_evt) |-> !sda_oe);

    // R5: no write byte is delivered while busy was seen at the decision
    a_r5_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && $past(prog_busy)) |-> !wr_valid);

    // R7: a write byte is a single-cycle pulse
    a_r7_write_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R8: commit only right after a STOP, never with a write byte
    a_r8_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(stop_evt) && !wr_valid));

    // R10: an increment of the offset leaves the block bits alone
    a_r10_inc_keeps_block: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_raddr[BLK_W-1:0] == BLK_W'($past(mem_raddr[BLK_W-1:0]) + 1'b1))
        |-> (mem_raddr[ADDR_W-1:BLK_W] == $past(mem_raddr[ADDR_W-1:BLK_W])));

endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_oe    (sda_oe),
    .prog_busy (prog_busy),
    .wr_valid  (wr_valid),
    .wr_commit (wr_commit),
    .mem_raddr (mem_raddr)
);

// File: tb/twi_mem_slave_bench.sv
// Bench: a behavioural bus master plus a reference model of the slave
// (expected drive per bit, pointer as an integer, write queue), compared
// on every system clock of each SCL high phase.
module twi_mem_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic prog_busy = 1'b0;
    logic [1:0] chip_sel = 2'b10;
    logic sda_oe, wr_valid, wr_commit;
    logic [8:0] mem_raddr, wr_addr;
    logic [7:0] mem_rdata, wr_data;
    wire  sda_bus = m_sda & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int commits = 0;
    int ref_ptr = 0;
    int exp_wa[$];
    int exp_wd[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory content as a function of the address
    function automatic logic [7:0] img(input logic [8:0] a);
        return 8'(a[7:0] * 8'd7 + 8'd3) ^ {a[8], 7'b0};
    endfunction

    assign mem_rdata = img(mem_raddr);

    twi_mem_slave u_twi_mem_slave (
        .clk (clk), .rst_n (rst_n), .scl_in (m_scl), .sda_in (sda_bus),
        .sda_oe (sda_oe), .chip_sel (chip_sel), .prog_busy (prog_busy),
        .mem_raddr (mem_raddr), .mem_rdata (mem_rdata), .wr_valid (wr_valid),
        .wr_addr (wr_addr), .wr_data (wr_data), .wr_commit (wr_commit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Write-port monitor against the expected write queue (R7, R10)
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_wa.size() == 0) check(1'b0, "R7 unexpected write", int'(wr_addr), -1);
            else begin
                int ea, ed;
                ea = exp_wa.pop_front();
                ed = exp_wd.pop_front();
                check(int'(wr_addr) == ea, "R7/R10 write address", int'(wr_addr), ea);
                check(int'(wr_data) == ed, "R7 write data", int'(wr_data), ed);
            end
        end
        if (rst_n && wr_commit) commits++;
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCL clock; compare drive with model on every clock of the high phase
    task automatic bus_bit(input logic b, input logic exp_oe, input string req, output logic seen);
        wait_q(Q);
        m_sda = b;
        wait_q(Q);
        m_scl = 1'b1;
        seen = 1'b1;
        for (int i = 0; i < 2*Q; i++) begin
            @(negedge clk);
            check(sda_oe === exp_oe, req, int'(sda_oe), int'(exp_oe));
            if (i == Q) seen = sda_bus;
        end
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_q(Q); m_sda = 1'b1;
        wait_q(Q); m_scl = 1'b1;
        wait_q(Q); m_sda = 1'b0;
        wait_q(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_q(Q); m_sda = 1'b0;
        wait_q(Q); m_scl = 1'b1;
        wait_q(Q); m_sda = 1'b1;
        wait_q(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, req, s);
        bus_bit(1'b1, exp_ack, req, s);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic m_ack, input string req);
        logic s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, ~exp[i], req, s);
            got[i] = s;
        end
        check(got == exp, req, int'(got), int'(exp));
        bus_bit(~m_ack, 1'b0, req, s);
    endtask

    function automatic logic [7:0] ctl(input logic [1:0] cs, input logic blk, input logic rd);
        return {4'b1010, cs, blk, rd};
    endfunction

    function automatic int bump(input int p);
        return (p & 256) | ((p + 1) & 255);
    endfunction

    // Read one byte at the model pointer and advance it
    task automatic model_read(input logic m_ack, input string req);
        recv_byte(img(9'(ref_ptr)), m_ack, req);
        ref_ptr = bump(ref_ptr);
    endtask

    task automatic model_write(input logic [7:0] d, input string req);
        exp_wa.push_back(ref_ptr);
        exp_wd.push_back(int'(d));
        send_byte(d, 1'b1, req);
        ref_ptr = bump(ref_ptr);
    endtask

    initial begin
        logic s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_q(4);
        // R1: reset state at the ports
        check(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
        check(wr_valid == 1'b0 && wr_commit == 1'b0, "R1 no write after reset",
              int'({wr_valid, wr_commit}), 0);

        // R3 R6 R7 R10 R8: write across the end of block 0
        bus_start();
        send_byte(ctl(2'b10, 1'b0, 1'b0), 1'b1, "R3 control ack");
        send_byte(8'hFE, 1'b1, "R6 word address ack");
        ref_ptr = 9'h0FE;
        model_write(8'h11, "R7 data ack");
        model_write(8'h22, "R7 data ack");
        model_write(8'h33, "R10 data ack after wrap");
        bus_stop();
        check(commits == 1, "R8 commit after write", commits, 1);
        check(exp_wa.size() == 0, "R7 all writes seen", exp_wa.size(), 0);

        // R6 R9 R10: random sequential read wrapping inside block 1
        bus_start();
        send_byte(ctl(2'b10, 1'b1, 1'b0), 1'b1, "R6 control ack");
        send_byte(8'hFE, 1'b1, "R6 word address ack");
        ref_ptr = 9'h1FE;
        bus_start();
        send_byte(ctl(2'b10, 1'b1, 1'b1), 1'b1, "R9 read control ack");
        model_read(1'b1, "R9 read 1FE");
        model_read(1'b1, "R10 read 1FF");
        model_read(1'b0, "R10 read 100 after wrap");
        bus_stop();
        check(commits == 1, "R8 no commit without data", commits, 1);

        // R11: current-address read
        bus_start();
        send_byte(ctl(2'b10, 1'b1, 1'b1), 1'b1, "R11 control ack");
        model_read(1'b0, "R11 current address read");
        bus_stop();

        // R4: chip select mismatch, then device code mismatch
        bus_start();
        send_byte(ctl(2'b01, 1'b0, 1'b0), 1'b0, "R4 chip select mismatch");
        send_byte(8'h55, 1'b0, "R4 later byte ignored");
        bus_stop();
        bus_start();
        send_byte({4'b1011, 2'b10, 1'b0, 1'b0}, 1'b0, "R4 device code mismatch");
        bus_stop();

        // R5: busy blocks control byte acks, write and read alike
        prog_busy = 1'b1;
        bus_start();
        send_byte(ctl(2'b10, 1'b0, 1'b0), 1'b0, "R5 busy write control");
        bus_stop();
        bus_start();
        send_byte(ctl(2'b10, 1'b0, 1'b1), 1'b0, "R5 busy read control");
        send_byte(8'hFF, 1'b0, "R5 busy no read data");
        bus_stop();
        prog_busy = 1'b0;

        // R2: START part-way through a control byte
        bus_start();
        for (int i = 7; i >= 4; i--) bus_bit(ctl(2'b10, 1'b0, 1'b0)[i], 1'b0, "R2 partial byte", s);
        bus_start();
        send_byte(ctl(2'b10, 1'b0, 1'b1), 1'b1, "R2 restart control ack");
        ref_ptr = (ref_ptr & 255);
        model_read(1'b0, "R2 read after restart");
        bus_stop();

        // R5: busy raised before the first data byte; no commit
        bus_start();
        send_byte(ctl(2'b10, 1'b0, 1'b0), 1'b1, "R5 control ack");
        send_byte(8'h40, 1'b1, "R5 word address ack");
        prog_busy = 1'b1;
        send_byte(8'h77, 1'b0, "R5 busy data no ack");
        prog_busy = 1'b0;
        bus_stop();
        check(commits == 1, "R5 no commit when busy", commits, 1);
        ref_ptr = 9'h040;

        // R10 R7 R8: write wrapping inside block 1, then read where it left off
        bus_start();
        send_byte(ctl(2'b10, 1'b1, 1'b0), 1'b1, "R7 control ack");
        send_byte(8'hFF, 1'b1, "R6 word address ack");
        ref_ptr = 9'h1FF;
        model_write(8'hA5, "R7 data ack");
        model_write(8'h5A, "R10 data ack after wrap");
        bus_stop();
        check(commits == 2, "R8 second commit", commits, 2);
        bus_start();
        send_byte(ctl(2'b10, 1'b1, 1'b1), 1'b1, "R11 control ack");
        model_read(1'b0, "R11 read after write");
        bus_stop();
        check(exp_wa.size() == 0, "R7 write queue drained", exp_wa.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule